// File: doc/BRIEF.md
# Hardware Microthread Fork/Join Scheduler

This block creates and reclaims lightweight threads in hardware. It owns a fixed pool of thread contexts. A fork request carries a start address and a snapshot of the parent's registers. If the queue of waiting work is empty and a context is free, the new thread starts in the lowest-numbered free context with that address and the same register image as its parent. Otherwise the request is appended to a first-in first-out pending queue, and no thread starts. Whenever a context is free and the queue holds work, the oldest entry is started there. A freed context therefore never sits idle while work is waiting.

The two halves of a fork can tell themselves apart by their return value. The parent gets an even number, twice its own context number, when its fork is accepted. The child gets an odd number, twice its context number plus one, when it starts.

A join pairs a child with its parent. Each side posts one value, in either order. When the second value arrives, the two are reduced with an add, a signed minimum or a signed maximum. The result goes to the parent and the child's context is released. An exit request releases a context directly. When the pending queue is full, fork requests are held off with a ready signal.

Top module: `mt_sched`

## Requirements
- R1: After reset, only context 0 is busy (`ctx_busy` = 1), the pending queue is empty, `fork_ready` is 1, and `start_valid`, `fork_ack` and `join_done` are 0.
- R2: A fork accepted while the queue is empty and a context is free causes `start_valid` in the next cycle. That start names the lowest-numbered free context and carries the request's `fork_pc` and `fork_snap` unchanged, and that context's busy bit is set.
- R3: One cycle after a fork is accepted, `fork_ack` is 1 with `fork_ack_ret` = 2 x `fork_parent`. Every start reports `start_ret` = 2 x `start_ctx` + 1.
- R4: A fork accepted while no context is free, or while the queue is not empty, starts no thread in the following cycle and is stored in the pending queue.
- R5: Once QDEPTH entries are pending, `pend_full` is 1 and `fork_ready` is 0. A fork presented then is ignored: no ack, no start, and nothing is stored.
- R6: A context freed by an exit becomes not busy after one edge. If entries are pending, the oldest one starts in the lowest free context at the following edge, so queued work starts in arrival order.
- R7: A join completes only after both the child (`join_is_parent`=0, `join_ctx`=child) and the parent (`join_is_parent`=1, `join_ctx`=parent, `join_peer`=child) have posted, in either order. One cycle after the second post, `join_done` is 1 with `join_dst` = parent and `join_child` = child, and the child's busy bit is cleared.
- R8: With `join_op` = 0 (and the spare code 3), the result is parent value + child value modulo 2^DATA_W.
- R9: With `join_op` = 1, the result is the smaller value, and with `join_op` = 2 it is the larger value. Both comparisons treat the values as signed two's complement. The operation used is the one the parent posts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fork_valid | input | 1 | Fork request |
| fork_parent | input | $clog2(NCTX) | Context issuing the fork |
| fork_pc | input | PC_W | Start address of the new thread |
| fork_snap | input | SNAP_W | Register image copied to the new thread |
| fork_ready | output | 1 | Fork can be accepted (queue not full) |
| fork_ack | output | 1 | Fork accepted in the previous cycle |
| fork_ack_ret | output | DATA_W | Even value returned to the parent |
| start_valid | output | 1 | A thread starts |
| start_ctx | output | $clog2(NCTX) | Context that starts |
| start_pc | output | PC_W | Its start address |
| start_snap | output | SNAP_W | Its register image |
| start_ret | output | DATA_W | Odd value returned to the child |
| exit_valid | input | 1 | Thread exit |
| exit_ctx | input | $clog2(NCTX) | Exiting context |
| join_valid | input | 1 | Join post |
| join_ctx | input | $clog2(NCTX) | Posting context |
| join_is_parent | input | 1 | Post comes from the parent side |
| join_peer | input | $clog2(NCTX) | Child context named by a parent post |
| join_op | input | 2 | Reduction: 0 add, 1 signed min, 2 signed max, 3 add |
| join_val | input | DATA_W | Posted value |
| join_done | output | 1 | Join completed |
| join_dst | output | $clog2(NCTX) | Parent receiving the result |
| join_child | output | $clog2(NCTX) | Child context released |
| join_result | output | DATA_W | Reduced value |
| ctx_busy | output | NCTX | Per-context busy flags |
| pend_empty | output | 1 | Pending queue empty |
| pend_full | output | 1 | Pending queue full |

## Verification
The assertions assume that the inputs are used correctly:
- An exit names a context that is busy and is not in the middle of a join.
- Each side of a join posts exactly once.
- A parent post names a child that has actually started.
- Exit and join completion never release the same context in the same cycle.

The stimulus keeps to these rules. It exits only contexts it has seen start. It completes every join before that context is reused. It always runs a fork/start step before the join that names the child started by that fork.

// File: rtl/mt_sched_pkg.sv
package mt_sched_pkg;

   typedef enum logic [1:0] {
      RED_ADD = 2'd0,
      RED_MIN = 2'd1,
      RED_MAX = 2'd2,
      RED_SPR = 2'd3
   } red_op_e;

endpackage

// File: rtl/mt_fifo.sv
module mt_fifo #(
   parameter int W     = 48,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = PW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("mt_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;

   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/mt_pick_free.sv
module mt_pick_free #(
   parameter int NCTX = 4
) (
   input  logic [NCTX-1:0]         busy,
   output logic                    any_free,
   output logic [$clog2(NCTX)-1:0] idx
);
   localparam int IDW = $clog2(NCTX);

   always_comb begin
      idx = '0;
      for (int i = NCTX - 1; i >= 0; i--) begin
         if (!busy[i]) idx = IDW'(i);
      end
   end

   assign any_free = ~&busy;

endmodule

// File: rtl/mt_join_unit.sv
module mt_join_unit
   import mt_sched_pkg::*;
#(
   parameter int NCTX   = 4,
   parameter int DATA_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    join_valid,
   input  logic [$clog2(NCTX)-1:0] join_ctx,
   input  logic                    join_is_parent,
   input  logic [$clog2(NCTX)-1:0] join_peer,
   input  logic [1:0]              join_op,
   input  logic [DATA_W-1:0]       join_val,
   output logic                    cmpl,
   output logic [$clog2(NCTX)-1:0] cmpl_slot,
   output logic                    join_done,
   output logic [$clog2(NCTX)-1:0] join_dst,
   output logic [$clog2(NCTX)-1:0] join_child,
   output logic [DATA_W-1:0]       join_result
);
   localparam int IDW = $clog2(NCTX);

   logic [NCTX-1:0]   have_c, have_p;
   logic [DATA_W-1:0] c_val [NCTX];
   logic [DATA_W-1:0] p_val [NCTX];
   logic [1:0]        p_op  [NCTX];
   logic [IDW-1:0]    p_id  [NCTX];

   logic [IDW-1:0]    slot;
   logic [DATA_W-1:0] a_par, b_chd, red;
   logic [1:0]        op_use;
   logic [IDW-1:0]    dst_use;

   assign slot      = join_is_parent ? join_peer : join_ctx;
   assign cmpl      = join_valid & (join_is_parent ? have_c[slot] : have_p[slot]);
   assign cmpl_slot = slot;
   assign a_par     = join_is_parent ? join_val : p_val[slot];
   assign b_chd     = join_is_parent ? c_val[slot] : join_val;
   assign op_use    = join_is_parent ? join_op : p_op[slot];
   assign dst_use   = join_is_parent ? join_ctx : p_id[slot];

   always_comb begin
      case (red_op_e'(op_use))
         RED_MIN: red = ($signed(a_par) < $signed(b_chd)) ? a_par : b_chd;
         RED_MAX: red = ($signed(a_par) > $signed(b_chd)) ? a_par : b_chd;
         default: red = a_par + b_chd;
      endcase
   end

   generate
      for (genvar g = 0; g < NCTX; g++) begin : g_slot
         logic hit;
         assign hit = join_valid && (slot == IDW'(g));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               have_c[g] <= 1'b0;
               have_p[g] <= 1'b0;
            end else if (hit) begin
               if (cmpl) begin
                  have_c[g] <= 1'b0;
                  have_p[g] <= 1'b0;
               end else if (join_is_parent) begin
                  have_p[g] <= 1'b1;
               end else begin
                  have_c[g] <= 1'b1;
               end
            end
         end
         always_ff @(posedge clk) begin
            if (hit && !cmpl) begin
               if (join_is_parent) begin
                  p_val[g] <= join_val;
                  p_op[g]  <= join_op;
                  p_id[g]  <= join_ctx;
               end else begin
                  c_val[g] <= join_val;
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         join_done   <= 1'b0;
         join_dst    <= '0;
         join_child  <= '0;
         join_result <= '0;
      end else begin
         join_done <= cmpl;
         if (cmpl) begin
            join_dst    <= dst_use;
            join_child  <= slot;
            join_result <= red;
         end
      end
   end

   a_r7_done_after_post: assert property (@(posedge clk) disable iff (!rst_n)
      join_done |-> $past(join_valid));
   a_r7_single_post_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (join_valid && !join_is_parent && !have_p[join_ctx]) |=> !join_done);

endmodule

// File: rtl/mt_sched.sv
module mt_sched #(
   parameter int NCTX   = 4,
   parameter int DATA_W = 16,
   parameter int PC_W   = 16,
   parameter int SNAP_W = 32,
   parameter int QDEPTH = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fork_valid,
   input  logic [$clog2(NCTX)-1:0] fork_parent,
   input  logic [PC_W-1:0]         fork_pc,
   input  logic [SNAP_W-1:0]       fork_snap,
   output logic                    fork_ready,
   output logic                    fork_ack,
   output logic [DATA_W-1:0]       fork_ack_ret,
   output logic                    start_valid,
   output logic [$clog2(NCTX)-1:0] start_ctx,
   output logic [PC_W-1:0]         start_pc,
   output logic [SNAP_W-1:0]       start_snap,
   output logic [DATA_W-1:0]       start_ret,
   input  logic                    exit_valid,
   input  logic [$clog2(NCTX)-1:0] exit_ctx,
   input  logic                    join_valid,
   input  logic [$clog2(NCTX)-1:0] join_ctx,
   input  logic                    join_is_parent,
   input  logic [$clog2(NCTX)-1:0] join_peer,
   input  logic [1:0]              join_op,
   input  logic [DATA_W-1:0]       join_val,
   output logic                    join_done,
   output logic [$clog2(NCTX)-1:0] join_dst,
   output logic [$clog2(NCTX)-1:0] join_child,
   output logic [DATA_W-1:0]       join_result,
   output logic [NCTX-1:0]         ctx_busy,
   output logic                    pend_empty,
   output logic                    pend_full
);
   localparam int IDW   = $clog2(NCTX);
   localparam int ENT_W = PC_W + SNAP_W;
   localparam int PADW  = DATA_W - IDW - 1;

   generate
      if (NCTX < 2 || (NCTX & (NCTX - 1)) != 0) begin : g_bad_nctx
         $error("mt_sched: NCTX must be a power of two of at least 2");
      end
      if (DATA_W < IDW + 2) begin : g_bad_dw
         $error("mt_sched: DATA_W too small to hold return values");
      end
   endgenerate

   logic             any_free;
   logic [IDW-1:0]   free_idx;
   logic             fork_go, direct, push, pop;
   logic [ENT_W-1:0] q_dout;
   logic             cmpl;
   logic [IDW-1:0]   cmpl_slot;
   logic [NCTX-1:0]  set_mask, clr_mask;

   mt_pick_free #(.NCTX(NCTX)) i_pick (
      .busy     (ctx_busy),
      .any_free (any_free),
      .idx      (free_idx)
   );

   mt_fifo #(.W(ENT_W), .DEPTH(QDEPTH)) i_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   ({fork_pc, fork_snap}),
      .pop   (pop),
      .dout  (q_dout),
      .empty (pend_empty),
      .full  (pend_full)
   );

   mt_join_unit #(.NCTX(NCTX), .DATA_W(DATA_W)) i_join (
      .clk            (clk),
      .rst_n          (rst_n),
      .join_valid     (join_valid),
      .join_ctx       (join_ctx),
      .join_is_parent (join_is_parent),
      .join_peer      (join_peer),
      .join_op        (join_op),
      .join_val       (join_val),
      .cmpl           (cmpl),
      .cmpl_slot      (cmpl_slot),
      .join_done      (join_done),
      .join_dst       (join_dst),
      .join_child     (join_child),
      .join_result    (join_result)
   );

   assign fork_ready = !pend_full;
   assign fork_go    = fork_valid && fork_ready;
   assign direct     = fork_go && pend_empty && any_free;
   assign push       = fork_go && !direct;
   assign pop        = !pend_empty && any_free;

   generate
      for (genvar g = 0; g < NCTX; g++) begin : g_mask
         assign set_mask[g] = (direct || pop) && (free_idx == IDW'(g));
         assign clr_mask[g] = (exit_valid && exit_ctx == IDW'(g)) ||
                              (cmpl && cmpl_slot == IDW'(g));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctx_busy <= NCTX'(1);
      end else begin
         ctx_busy <= (ctx_busy & ~clr_mask) | set_mask;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_valid  <= 1'b0;
         start_ctx    <= '0;
         start_pc     <= '0;
         start_snap   <= '0;
         fork_ack     <= 1'b0;
         fork_ack_ret <= '0;
      end else begin
         start_valid <= direct || pop;
         fork_ack    <= fork_go;
         if (direct || pop) begin
            start_ctx <= free_idx;
            {start_pc, start_snap} <= pop ? q_dout : {fork_pc, fork_snap};
         end
         if (fork_go) fork_ack_ret <= {{PADW{1'b0}}, fork_parent, 1'b0};
      end
   end

   assign start_ret = {{PADW{1'b0}}, start_ctx, 1'b1};

   a_r2_start_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start_valid |-> ctx_busy[start_ctx]);
   a_r2_one_start: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_mask));
   a_r4_no_start_when_full_pool: assert property (@(posedge clk) disable iff (!rst_n)
      (&ctx_busy) |=> !start_valid);
   a_r6_pending_served: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_empty && any_free) |=> start_valid);
   a_r7_child_released: assert property (@(posedge clk) disable iff (!rst_n)
      join_done |-> !ctx_busy[join_child]);

endmodule

// File: tb/test_mt_sched.sv
module test_mt_sched;
   localparam int CLK_P  = 10;
   localparam int NCTX   = 4;
   localparam int DW     = 16;
   localparam int PW     = 16;
   localparam int SW     = 32;
   localparam int QD     = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          fork_valid;
   logic [1:0]    fork_parent;
   logic [PW-1:0] fork_pc;
   logic [SW-1:0] fork_snap;
   logic          fork_ready, fork_ack;
   logic [DW-1:0] fork_ack_ret;
   logic          start_valid;
   logic [1:0]    start_ctx;
   logic [PW-1:0] start_pc;
   logic [SW-1:0] start_snap;
   logic [DW-1:0] start_ret;
   logic          exit_valid;
   logic [1:0]    exit_ctx;
   logic          join_valid, join_is_parent;
   logic [1:0]    join_ctx, join_peer, join_op;
   logic [DW-1:0] join_val;
   logic          join_done;
   logic [1:0]    join_dst, join_child;
   logic [DW-1:0] join_result;
   logic [3:0]    ctx_busy;
   logic          pend_empty, pend_full;

   int total = 0;
   int bad   = 0;

   always #(CLK_P/2) clk = ~clk;

   mt_sched #(.NCTX(NCTX), .DATA_W(DW), .PC_W(PW), .SNAP_W(SW), .QDEPTH(QD)) i_mt_sched (
      .clk(clk), .rst_n(rst_n),
      .fork_valid(fork_valid), .fork_parent(fork_parent), .fork_pc(fork_pc),
      .fork_snap(fork_snap), .fork_ready(fork_ready), .fork_ack(fork_ack),
      .fork_ack_ret(fork_ack_ret), .start_valid(start_valid), .start_ctx(start_ctx),
      .start_pc(start_pc), .start_snap(start_snap), .start_ret(start_ret),
      .exit_valid(exit_valid), .exit_ctx(exit_ctx),
      .join_valid(join_valid), .join_ctx(join_ctx), .join_is_parent(join_is_parent),
      .join_peer(join_peer), .join_op(join_op), .join_val(join_val),
      .join_done(join_done), .join_dst(join_dst), .join_child(join_child),
      .join_result(join_result), .ctx_busy(ctx_busy),
      .pend_empty(pend_empty), .pend_full(pend_full)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      fork_valid = 0; exit_valid = 0; join_valid = 0;
   endtask

   task automatic do_fork(input int parent, input int pc, input int snap);
      idle();
      fork_valid = 1; fork_parent = 2'(parent);
      fork_pc = PW'(pc); fork_snap = SW'(snap);
      tick();
      idle();
   endtask

   task automatic do_exit(input int c);
      idle();
      exit_valid = 1; exit_ctx = 2'(c);
      tick();
      idle();
   endtask

   task automatic post(input int c, input bit par, input int peer, input int op, input int v);
      idle();
      join_valid = 1; join_ctx = 2'(c); join_is_parent = par;
      join_peer = 2'(peer); join_op = 2'(op); join_val = DW'(v);
      tick();
      idle();
   endtask

   function automatic logic [DW-1:0] ref_red(input int op, input int a, input int b);
      case (op)
         1:       return DW'((a < b) ? a : b);
         2:       return DW'((a > b) ? a : b);
         default: return DW'(a + b);
      endcase
   endfunction

   initial begin
      #(CLK_P * 200000);
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int vals [6];
      int k;
      vals = '{0, 1, -1, 32767, -32768, 5};
      rst_n = 0; idle();
      fork_parent = 0; fork_pc = 0; fork_snap = 0; exit_ctx = 0;
      join_ctx = 0; join_is_parent = 0; join_peer = 0; join_op = 0; join_val = 0;
      repeat (3) tick();
      rst_n = 1;
      tick();
      // R1 reset state
      chk("R1 busy", 64'(ctx_busy), 64'h1);
      chk("R1 empty", 64'(pend_empty), 1);
      chk("R1 ready", 64'(fork_ready), 1);
      chk("R1 quiet", 64'({start_valid, fork_ack, join_done}), 0);

      // R2/R3 direct starts fill the pool
      for (int i = 1; i < 4; i++) begin
         do_fork(i - 1, 100 + i, 32'hA000_0000 + i);
         chk("R2 start", 64'(start_valid), 1);
         chk("R2 ctx", 64'(start_ctx), 64'(i));
         chk("R2 pc", 64'(start_pc), 64'(100 + i));
         chk("R2 snap", 64'(start_snap), 64'(32'hA000_0000 + i));
         chk("R3 child ret", 64'(start_ret), 64'(2 * i + 1));
         chk("R3 ack", 64'(fork_ack), 1);
         chk("R3 parent ret", 64'(fork_ack_ret), 64'(2 * (i - 1)));
      end
      chk("R2 busy", 64'(ctx_busy), 64'hF);

      // R4 queued forks
      for (int i = 0; i < QD; i++) begin
         do_fork(1, 200 + i, 32'h5000 + i);
         chk("R4 no start", 64'(start_valid), 0);
         chk("R3 ack queued", 64'(fork_ack_ret), 64'd2);
      end
      chk("R5 full", 64'(pend_full), 1);
      chk("R5 not ready", 64'(fork_ready), 0);
      do_fork(0, 999, 999);
      chk("R5 ignored ack", 64'(fork_ack), 0);
      chk("R5 ignored start", 64'(start_valid), 0);
      chk("R5 still full", 64'(pend_full), 1);

      // R6 exit frees, oldest pending starts
      do_exit(2);
      chk("R6 freed", 64'(ctx_busy), 64'hB);
      chk("R6 no start yet", 64'(start_valid), 0);
      tick();
      chk("R6 start", 64'(start_valid), 1);
      chk("R6 ctx", 64'(start_ctx), 2);
      chk("R6 oldest pc", 64'(start_pc), 200);
      chk("R6 snap", 64'(start_snap), 64'h5000);
      chk("R3 queued ret", 64'(start_ret), 5);
      chk("R6 not full", 64'(pend_full), 0);

      // R7 join frees child, next pending starts there
      post(3, 0, 0, 0, 10);
      chk("R7 half wait", 64'(join_done), 0);
      post(0, 1, 3, 0, 20);
      chk("R7 done", 64'(join_done), 1);
      chk("R7 dst", 64'(join_dst), 0);
      chk("R7 child", 64'(join_child), 3);
      chk("R8 add", 64'(join_result), 30);
      chk("R7 released", 64'(ctx_busy), 64'h7);
      tick();
      chk("R6 refill ctx", 64'(start_ctx), 3);
      chk("R6 refill pc", 64'(start_pc), 201);

      // R6 drain in arrival order
      for (int i = 2; i < QD; i++) begin
         k = 1 + (i % 3);
         do_exit(k);
         tick();
         chk("R6 drain start", 64'(start_valid), 1);
         chk("R6 drain ctx", 64'(start_ctx), 64'(k));
         chk("R6 drain order", 64'(start_pc), 64'(200 + i));
      end
      chk("R6 drained", 64'(pend_empty), 1);
      for (int c = 1; c < 4; c++) do_exit(c);
      tick();
      chk("R6 idle", 64'(start_valid), 0);
      chk("R6 only root", 64'(ctx_busy), 64'h1);

      // R7/R8/R9 reduction sweep, both posting orders
      for (int op = 0; op < 4; op++) begin
         for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
               do_fork(0, 300 + i * 6 + j, op);
               chk("R2 sweep ctx", 64'(start_ctx), 1);
               if (((i + j) & 1) == 0) begin
                  post(1, 0, 0, 0, vals[j]);
                  chk("R7 sweep wait", 64'(join_done), 0);
                  post(0, 1, 1, op, vals[i]);
               end else begin
                  post(0, 1, 1, op, vals[i]);
                  chk("R7 sweep wait", 64'(join_done), 0);
                  post(1, 0, 0, 0, vals[j]);
               end
               chk("R7 sweep done", 64'(join_done), 1);
               chk("R7 sweep dst", 64'(join_dst), 0);
               if (op == 1 || op == 2)
                  chk("R9 signed minmax", 64'(join_result), 64'(ref_red(op, vals[i], vals[j])));
               else
                  chk("R8 wrap add", 64'(join_result), 64'(ref_red(op, vals[i], vals[j])));
               chk("R7 sweep free", 64'(ctx_busy[1]), 0);
            end
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule